// File: doc/BRIEF.md
# PC-Relative Address and Load Unit

This unit executes one family of instructions that share a single major opcode and all work relative to the address of the instruction itself. It receives a 32-bit instruction word together with the 64-bit address it was fetched from. Address-forming operations produce a register write on the next cycle. Load operations issue one memory read request, wait for the response, and then write the loaded and extended data to the register write port.

The operation is picked by a prefix-coded selector at the top of the 21-bit field below the destination register. The selector is 2, 3 or 5 bits wide, and the rest of the field is the immediate. Because of this, the immediate width, its scaling and the alignment of the base address all depend on the operation. Encodings that are reserved, and 64-bit-only loads issued in 32-bit mode, raise a one-cycle reserved-instruction flag. The register file, the memory system and address translation are outside this unit.

Top module: `pcrel_unit`

## Requirements
- R1: After reset, `wb_valid`, `mem_req_valid` and `rsvd_insn` are low and `issue_ready` is high.
- R2: When bits 31:26 equal 0x3B and bits 20:19 equal 00, the operation is add-to-PC. On the cycle after issue, `wb_valid` is high, `wb_reg` equals bits 25:21, and `wb_data` equals pc + sign-extended bits 18:0 times 4.
- R3: Bits 20:16 equal to 11110 write pc + (sign-extended bits 15:0 shifted left 16). Bits 20:16 equal to 11111 write the same sum with its low 16 bits cleared. Both writes appear on the cycle after issue.
- R4: The three address-forming operations make no register write when bits 25:21 are 0.
- R5: Bits 20:19 equal to 01 select the signed word load. The unit raises `mem_req_valid` the cycle after issue, with address pc + sign-extended bits 18:0 times 4 and `mem_req_size` 0. One cycle after `mem_rsp_valid`, it writes `mem_rsp_data[31:0]` sign-extended to 64 bits.
- R6: Bits 20:19 equal to 10 select the unsigned word load: size 1, same address rule as R5, data zero-extended. Bits 20:18 equal to 110 select the doubleword load: size 2, address (pc with bits 2:0 cleared) + sign-extended bits 17:0 times 8, and all 64 data bits written.
- R7: With `mode64` low, the unsigned word load and the doubleword load raise `rsvd_insn` on the cycle after issue. They issue no memory request and make no register write.
- R8: Bits 20:17 equal to 1110 raise `rsvd_insn` for exactly one cycle after issue, with no register write and no request.
- R9: With `mode64` high, address sums wrap modulo 2^64. With `mode64` low, every formed address and result is bit 31 of the sum sign-extended to 64 bits.
- R10: `issue_ready` is low from the cycle after a load issues until its write-back. A pending request keeps its address and size stable until `mem_req_ready` is seen.
- R11: An issued word whose bits 31:26 are not 0x3B causes no write, no request and no reserved flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Instruction presented |
| issue_ready | output | 1 | Unit idle and able to accept |
| insn | input | 32 | Instruction word |
| pc | input | 64 | Address of the instruction |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| mem_req_valid | output | 1 | Memory read request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Read address |
| mem_req_size | output | 2 | 0 signed word, 1 unsigned word, 2 doubleword |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Read data |
| wb_valid | output | 1 | Register write strobe (one cycle) |
| wb_reg | output | 5 | Destination register number |
| wb_data | output | 64 | Value written |
| rsvd_insn | output | 1 | Reserved-instruction pulse |

## Verification
The address-forming operations are driven with positive and negative immediates. This shows that each selector width picks the correct immediate slice and scale. Sums that cross bit 31 in 32-bit mode, and sums that wrap past 2^64 in 64-bit mode, separate the narrowing rule from plain addition. Each load uses an unaligned PC and response data with bit 31 set, so sign extension, zero extension and base alignment each give a different value. The reserved pattern, the 64-bit-only loads in 32-bit mode, destination zero and a foreign major opcode check that nothing is written or requested when nothing should be.

// File: rtl/pcrel_pkg.sv
// Shared types of the PC-relative unit: decoded operation, load size, FSM state.
package pcrel_pkg;
    typedef enum logic [2:0] {
        OP_NONE, OP_ADDPC, OP_LWS, OP_LWU, OP_LD, OP_AUIPC, OP_ALUIPC, OP_RSVD
    } pcrel_op_e;

    // Size codes seen on the memory request port.
    typedef enum logic [1:0] {
        SZ_WORD_S = 2'd0,
        SZ_WORD_U = 2'd1,
        SZ_DWORD  = 2'd2
    } ld_size_e;

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} pcrel_st_e;
endpackage

// File: rtl/pcrel_decode.sv
// Decoder: turns the instruction word into an operation, a scaled offset,
// a base-alignment flag and a load size. Assumes XLEN >= 32 and ILEN == 32.
module pcrel_decode
    import pcrel_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int ILEN  = 32,
    parameter logic [5:0] MAJOR = 6'h3B
) (
    input  logic [ILEN-1:0] insn,
    input  logic            mode64,
    output pcrel_op_e       op,
    output logic [4:0]      rd,
    output logic [XLEN-1:0] offset,
    output logic            align8,
    output logic            clr_low,
    output ld_size_e        size
);
    logic [XLEN-1:0] off_w, off_d, off_u;

    // Offset candidates: 19-bit x4, 18-bit x8, 16-bit upper immediate.
    always_comb begin
        off_w = {{(XLEN-21){insn[18]}}, insn[18:0], 2'b00};
        off_d = {{(XLEN-21){insn[17]}}, insn[17:0], 3'b000};
        off_u = {{(XLEN-32){insn[15]}}, insn[15:0], 16'h0000};
    end

    // Prefix decode of the selector with 64-bit-only checks.
    always_comb begin
        op      = OP_NONE;
        offset  = off_w;
        align8  = 1'b0;
        clr_low = 1'b0;
        size    = SZ_WORD_S;
        rd      = insn[25:21];
        if (insn[31:26] == MAJOR) begin
            if (insn[20:19] == 2'b00) begin
                op = OP_ADDPC;
            end else if (insn[20:19] == 2'b01) begin
                op = OP_LWS;
            end else if (insn[20:19] == 2'b10) begin
                op   = mode64 ? OP_LWU : OP_RSVD;
                size = SZ_WORD_U;
            end else if (insn[18] == 1'b0) begin
                op     = mode64 ? OP_LD : OP_RSVD;
                offset = off_d;
                align8 = 1'b1;
                size   = SZ_DWORD;
            end else if (insn[17] == 1'b0) begin
                op = OP_RSVD;
            end else begin
                offset  = off_u;
                op      = insn[16] ? OP_ALUIPC : OP_AUIPC;
                clr_low = insn[16];
            end
        end
    end
endmodule

// File: rtl/pcrel_addr.sv
// Address former: aligns the base, adds the offset, narrows in 32-bit mode
// and optionally clears the low 16 bits. Purely combinational.
module pcrel_addr #(
    parameter int XLEN  = 64,
    parameter int NARW  = 32,
    parameter int CLRW  = 16
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] offset,
    input  logic            align8,
    input  logic            clr_low,
    input  logic            mode64,
    output logic [XLEN-1:0] addr
);
    localparam logic [XLEN-1:0] ALIGN_MASK = {{(XLEN-3){1'b1}}, 3'b000};
    localparam logic [XLEN-1:0] CLR_MASK   = {{(XLEN-CLRW){1'b1}}, {CLRW{1'b0}}};

    logic [XLEN-1:0] base, sum, narrowed;

    // Base alignment, modular add, mode narrowing, low-bit clear.
    always_comb begin
        base     = align8 ? (pc & ALIGN_MASK) : pc;
        sum      = base + offset;
        narrowed = mode64 ? sum : {{(XLEN-NARW){sum[NARW-1]}}, sum[NARW-1:0]};
        addr     = clr_low ? (narrowed & CLR_MASK) : narrowed;
    end
endmodule

// File: rtl/pcrel_ldext.sv
// Load data extender: sign- or zero-extends a word, or passes a doubleword.
module pcrel_ldext
    import pcrel_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WRDW = 32
) (
    input  ld_size_e        size,
    input  logic [XLEN-1:0] raw,
    output logic [XLEN-1:0] data
);
    // Select the extension rule by load size.
    always_comb begin
        case (size)
            SZ_WORD_S: data = {{(XLEN-WRDW){raw[WRDW-1]}}, raw[WRDW-1:0]};
            SZ_WORD_U: data = {{(XLEN-WRDW){1'b0}}, raw[WRDW-1:0]};
            default:   data = raw;
        endcase
    end
endmodule

// File: rtl/pcrel_unit.sv
// PC-relative unit top: accepts one instruction when idle, writes formed
// addresses on the next cycle, and runs loads through a request / wait
// sequence. Assumes the memory returns exactly one response per accepted request.
module pcrel_unit
    import pcrel_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int ILEN = 32,
    parameter int REGW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    output logic            issue_ready,
    input  logic [ILEN-1:0] insn,
    input  logic [XLEN-1:0] pc,
    input  logic            mode64,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [XLEN-1:0] mem_req_addr,
    output logic [1:0]      mem_req_size,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_data,
    output logic            wb_valid,
    output logic [REGW-1:0] wb_reg,
    output logic [XLEN-1:0] wb_data,
    output logic            rsvd_insn
);
    pcrel_op_e       op;
    logic [4:0]      rd;
    logic [XLEN-1:0] offset, addr, ext_data;
    logic            align8, clr_low;
    ld_size_e        dec_size, req_size;
    pcrel_st_e       state;
    logic [REGW-1:0] ld_reg;

    pcrel_decode #(.XLEN(XLEN), .ILEN(ILEN)) u_dec (
        .insn(insn), .mode64(mode64), .op(op), .rd(rd), .offset(offset),
        .align8(align8), .clr_low(clr_low), .size(dec_size)
    );

    pcrel_addr #(.XLEN(XLEN)) u_addr (
        .pc(pc), .offset(offset), .align8(align8), .clr_low(clr_low),
        .mode64(mode64), .addr(addr)
    );

    pcrel_ldext #(.XLEN(XLEN)) u_ext (
        .size(req_size), .raw(mem_rsp_data), .data(ext_data)
    );

    // Port views of the sequencer state.
    always_comb begin
        issue_ready   = (state == ST_IDLE);
        mem_req_valid = (state == ST_REQ);
        mem_req_size  = req_size;
    end

    // Sequencer: issue, request, wait for data, write back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            mem_req_addr <= '0;
            req_size     <= SZ_WORD_S;
            ld_reg       <= '0;
            wb_valid     <= 1'b0;
            wb_reg       <= '0;
            wb_data      <= '0;
            rsvd_insn    <= 1'b0;
        end else begin
            wb_valid  <= 1'b0;
            rsvd_insn <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (issue_valid) begin
                        case (op)
                            OP_ADDPC, OP_AUIPC, OP_ALUIPC: begin
                                if (rd != 5'd0) begin
                                    wb_valid <= 1'b1;
                                    wb_reg   <= REGW'(rd);
                                    wb_data  <= addr;
                                end
                            end
                            OP_LWS, OP_LWU, OP_LD: begin
                                state        <= ST_REQ;
                                mem_req_addr <= addr;
                                req_size     <= dec_size;
                                ld_reg       <= REGW'(rd);
                            end
                            OP_RSVD: rsvd_insn <= 1'b1;
                            default: ;
                        endcase
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) state <= ST_WAIT;
                end
                default: begin
                    if (mem_rsp_valid) begin
                        wb_valid <= 1'b1;
                        wb_reg   <= ld_reg;
                        wb_data  <= ext_data;
                        state    <= ST_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/pcrel_unit_chk.sv
// Checker for pcrel_unit: handshake stability, exclusivity of outputs,
// narrowing and low-bit clearing of formed results. Bound to the top below.
module pcrel_unit_chk #(
    parameter int XLEN = 64,
    parameter int ILEN = 32,
    parameter int REGW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue_valid,
    input logic            issue_ready,
    input logic [ILEN-1:0] insn,
    input logic            mode64,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [XLEN-1:0] mem_req_addr,
    input logic [1:0]      mem_req_size,
    input logic            wb_valid,
    input logic [XLEN-1:0] wb_data,
    input logic            rsvd_insn
);
    // R10: a waiting request holds its address and size.
    a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size));

    // R10: no new instruction accepted while a request is pending.
    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !issue_ready);

    // R8: write, request and reserved flag never coincide.
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_valid, mem_req_valid, rsvd_insn}));

    // R9: a 32-bit-mode address-form result is sign-extended from bit 31.
    a_r9_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && $past(issue_valid && issue_ready && !mode64 && insn[31:26] == 6'h3B)
            |-> wb_data[XLEN-1:32] == {(XLEN-32){wb_data[31]}});

    // R3: the clearing upper-immediate form leaves the low 16 bits zero.
    a_r3_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && $past(issue_valid && issue_ready && insn[31:26] == 6'h3B && insn[20:16] == 5'h1F)
            |-> wb_data[15:0] == 16'h0000);
endmodule

bind pcrel_unit pcrel_unit_chk #(.XLEN(XLEN), .ILEN(ILEN), .REGW(REGW)) u_chk (.*);

// File: tb/pcrel_unit_bench.sv
// Bench for pcrel_unit: vector table for single-cycle operations, then
// directed load sequences with a hand-driven memory side.
module pcrel_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic        issue_ready;
    logic [31:0] insn = '0;
    logic [63:0] pc = '0;
    logic        mode64 = 1'b1;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic [1:0]  mem_req_size;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        wb_valid;
    logic [4:0]  wb_reg;
    logic [63:0] wb_data;
    logic        rsvd_insn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pcrel_unit u_pcrel_unit (.*);

    always #4 clk = ~clk;

    typedef struct packed {
        logic [31:0] i;
        logic [63:0] p;
        logic        m;
        logic        we;
        logic [4:0]  r;
        logic [63:0] d;
        logic        ri;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{32'hEC600010, 64'h1000, 1'b1, 1'b1, 5'd3, 64'h1040, 1'b0},                  // R2 positive
        '{32'hECA7FFFF, 64'h1000, 1'b1, 1'b1, 5'd5, 64'h0FFC, 1'b0},                  // R2 negative
        '{32'hECFE0002, 64'h1_0000_1234, 1'b1, 1'b1, 5'd7, 64'h1_0002_1234, 1'b0},    // R3 upper add
        '{32'hECFFFFFF, 64'h1_0002_1234, 1'b1, 1'b1, 5'd7, 64'h1_0001_0000, 1'b0},    // R3 upper add, clear
        '{32'hEC000010, 64'h1000, 1'b1, 1'b0, 5'd0, 64'h0, 1'b0},                     // R4 dest zero
        '{32'hEC3C0000, 64'h1000, 1'b1, 1'b0, 5'd0, 64'h0, 1'b1},                     // R8 reserved
        '{32'hEC400001, 64'h7FFF_FFFC, 1'b0, 1'b1, 5'd2, 64'hFFFF_FFFF_8000_0000, 1'b0}, // R9 narrow
        '{32'hEC800008, 64'hFFFF_FFFF_FFFF_FFF0, 1'b1, 1'b1, 5'd4, 64'h10, 1'b0},     // R9 wrap
        '{32'h3C600010, 64'h1000, 1'b1, 1'b0, 5'd0, 64'h0, 1'b0},                     // R11 other opcode
        '{32'hEC300004, 64'h1000, 1'b0, 1'b0, 5'd0, 64'h0, 1'b1},                     // R7 unsigned word in 32-bit
        '{32'hEC380000, 64'h1000, 1'b0, 1'b0, 5'd0, 64'h0, 1'b1},                     // R7 doubleword in 32-bit
        '{32'hECFF0001, 64'h7FFF_8000, 1'b0, 1'b1, 5'd7, 64'hFFFF_FFFF_8000_0000, 1'b0}, // R3 R9 clear narrowed
        '{32'hEC1E0001, 64'h1000, 1'b1, 1'b0, 5'd0, 64'h0, 1'b0}                      // R4 upper, dest zero
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One load: issue, stalled request, accept, response, write-back, idle.
    task automatic do_load(input string req, input logic [31:0] ins, input logic [63:0] p, input logic m,
                           input logic [63:0] exp_addr, input logic [1:0] exp_size,
                           input logic [63:0] rsp, input logic [4:0] exp_reg, input logic [63:0] exp_data);
        @(negedge clk);
        issue_valid = 1'b1; insn = ins; pc = p; mode64 = m;
        @(posedge clk);
        @(negedge clk);
        issue_valid = 1'b0;
        check(mem_req_valid && !issue_ready && mem_req_addr == exp_addr && mem_req_size == exp_size,
              {req, " request"}, {mem_req_addr[61:0], mem_req_size}, {exp_addr[61:0], exp_size});
        @(negedge clk);
        check(mem_req_valid && mem_req_addr == exp_addr && !issue_ready,
              "R10 request held", mem_req_addr, exp_addr);
        mem_req_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mem_req_ready = 1'b0;
        @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_data = rsp;
        @(posedge clk);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check(wb_valid && wb_reg == exp_reg && wb_data == exp_data,
              {req, " write-back"}, wb_data, exp_data);
        @(negedge clk);
        check(!wb_valid && issue_ready && !mem_req_valid,
              "R10 idle after load", {61'd0, wb_valid, issue_ready, mem_req_valid}, 64'b010);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!wb_valid && !mem_req_valid && !rsvd_insn && issue_ready, "R1 reset state",
              {60'd0, wb_valid, mem_req_valid, rsvd_insn, issue_ready}, 64'b0001);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            issue_valid = 1'b1; insn = VEC[k].i; pc = VEC[k].p; mode64 = VEC[k].m;
            @(posedge clk);
            @(negedge clk);
            issue_valid = 1'b0;
            check(wb_valid == VEC[k].we && rsvd_insn == VEC[k].ri && !mem_req_valid &&
                  (!VEC[k].we || (wb_reg == VEC[k].r && wb_data == VEC[k].d)),
                  $sformatf("vector %0d (R2 R3 R4 R7 R8 R9 R11)", k),
                  VEC[k].we ? wb_data : {62'd0, wb_valid, rsvd_insn},
                  VEC[k].we ? VEC[k].d : {62'd0, VEC[k].we, VEC[k].ri});
        end

        do_load("R5 signed word", 32'hED280003, 64'h2000, 1'b1, 64'h200C, 2'd0,
                64'h1234_5678_8765_4321, 5'd9, 64'hFFFF_FFFF_8765_4321);
        do_load("R6 unsigned word", 32'hED57FFFF, 64'h2000, 1'b1, 64'h1FFC, 2'd1,
                64'h1234_5678_8765_4321, 5'd10, 64'h0000_0000_8765_4321);
        do_load("R6 doubleword", 32'hED780002, 64'h2007, 1'b1, 64'h2010, 2'd2,
                64'h1234_5678_8765_4321, 5'd11, 64'h1234_5678_8765_4321);
        do_load("R6 doubleword negative", 32'hED7BFFFF, 64'h200F, 1'b1, 64'h2000, 2'd2,
                64'hFEDC_BA98_7654_3210, 5'd11, 64'hFEDC_BA98_7654_3210);
        do_load("R5 R9 signed word 32-bit", 32'hED280001, 64'h7FFF_FFFC, 1'b0,
                64'hFFFF_FFFF_8000_0000, 2'd0, 64'h0000_0000_0000_0042, 5'd9, 64'h42);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule